// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns activity on a small set of dedicated external interrupt pins into interrupt requests. Each pin has its own 2-bit sense field. The field selects one of four conditions: a held low level, any change, a falling edge or a rising edge. Edge conditions are found on a copy of the pin that passes through a two-flop synchronizer. A found edge sets a sticky pending flag. The flag stays set until an acknowledge pulse clears it, or until software writes a one to it. In low-level mode the pending state simply follows the synchronized pin and is never latched.

A request leaves the block only when the global enable and that pin's mask bit are both set. A combinational wake output covers the low-level condition directly from the raw pin, so it works while the clock is stopped. Software can trigger its own interrupt by driving the pin, because detection looks only at the pin value and not at its direction. A small register port gives access to the sense register, the mask register and the pending register.

Top module: `ext_irq_sense`

## Requirements
- R1: The sense register is at address 0. Pin i's field is in bits 2i+1:2i, so pin 1 uses 3:2 and pin 0 uses 1:0. The bits above the fields always read as zero and are not changed by writes.
- R2: Sense code 00 selects low level. While pin i's synchronized value is low, bit i of the pending register (address 2) reads 1. That bit reads 0 again two clocks after the pin returns high, with no latching.
- R3: Sense code 10 selects falling edge. A high-to-low change on the pin that lasts longer than one clock period sets the sticky pending bit by the third rising clock edge after the change. A rising change does not set it.
- R4: Sense code 11 selects rising edge. A low-to-high change sets the sticky pending bit. A falling change does not set it.
- R5: Sense code 01 selects any change. Both rising and falling changes set the sticky pending bit.
- R6: A pending edge flag is cleared by a one on ack_i[i], or by a register write of 1 to bit i of address 2. Writing 0 to that bit leaves the flag unchanged. If a new edge and a clear fall in the same cycle, the edge wins.
- R7: irq_o[i] is 1 only when bit i is pending, bit i of the mask register (address 1) is 1 and gie_i is 1.
- R8: wake_o is 1, with no clock edge needed, whenever some pin is low, its sense code is 00 and its mask bit is set.
- R9: A write to the sense register suppresses edge detection in that cycle and reloads the previous-value register, so changing the mode never sets a flag by itself.
- R10: After reset the sense, mask and pending registers read zero, and irq_o and wake_o are low while the pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | N | Raw external interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | N | Per-pin acknowledge, clears the pending flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 sense, 1 mask, 2 pending |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational |
| irq_o | output | N | Per-pin interrupt request |
| wake_o | output | 1 | Asynchronous low-level wake indication |

## Verification
The bench writes the sense register in the exact cycle that the synchronized copy of a falling edge reaches the comparator. A design that does not reload the previous-value register on a mode write would then raise a spurious flag. It drives a pin low with the clock held and checks the wake output, which catches a wake path that was registered by mistake. Low-level mode is checked to drop as soon as the pin goes high again; a design that latched it would keep the request. Each edge mode gets the wrong-direction edge as well as the right one, and flags are checked to survive an ack on the other pin and a write of zero.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] sense_i,
  input  logic       mode_wr_i,
  input  logic       clr_i,
  output logic       edge_o,
  output logic       pend_o,
  output logic       low_async_o
);
  sense_e sense;
  logic   sync;
  logic   prev_q;
  logic   flag_q;
  logic   rise, fall, hit;

  assign sense = sense_e'(sense_i);

  ext_irq_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  // prev reloads every cycle, including the mode-write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync;
  end

  assign rise = sync & ~prev_q;
  assign fall = ~sync & prev_q;

  always_comb begin
    unique case (sense)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  assign edge_o = hit & ~mode_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (sense == SENSE_LOW) flag_q <= 1'b0;
    else if (edge_o)            flag_q <= 1'b1;
    else if (clr_i)             flag_q <= 1'b0;
  end

  assign pend_o      = (sense == SENSE_LOW) ? ~sync : flag_q;
  assign low_async_o = (sense == SENSE_LOW) & ~pin_i;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int N  = 2,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  pend_i,
  output logic [DW-1:0] rdata_o,
  output logic [2*N-1:0] sense_o,
  output logic [N-1:0]  mask_o,
  output logic          mode_wr_o,
  output logic [N-1:0]  w1c_o
);
  localparam logic [DW-1:0] CTRL_BITS = DW'((1 << (2 * N)) - 1);
  localparam logic [DW-1:0] MASK_BITS = DW'((1 << N) - 1);

  logic [DW-1:0] ctrl_q, mask_q;
  logic wr_ctrl, wr_mask, wr_flag;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_mask = we_i && (addr_i == ADDR_MASK);
  assign wr_flag = we_i && (addr_i == ADDR_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i & CTRL_BITS;
      if (wr_mask) mask_q <= wdata_i & MASK_BITS;
    end
  end

  assign sense_o   = ctrl_q[2*N-1:0];
  assign mask_o    = mask_q[N-1:0];
  assign mode_wr_o = wr_ctrl;
  assign w1c_o     = wr_flag ? wdata_i[N-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_MASK: rdata_o = mask_q;
      ADDR_FLAG: rdata_o[N-1:0] = pend_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int N  = 2,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pin_i,
  input  logic          gie_i,
  input  logic [N-1:0]  ack_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [N-1:0]  irq_o,
  output logic          wake_o
);
  logic [2*N-1:0] sense;
  logic [N-1:0]   mask_q;
  logic           mode_wr;
  logic [N-1:0]   w1c;
  logic [N-1:0]   pend;
  logic [N-1:0]   edge_evt;
  logic [N-1:0]   low_async;
  logic [N-1:0]   lvl_sel;

  ext_irq_regs #(.N(N), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .pend_i   (pend),
    .rdata_o  (reg_rdata_o),
    .sense_o  (sense),
    .mask_o   (mask_q),
    .mode_wr_o(mode_wr),
    .w1c_o    (w1c)
  );

  for (genvar i = 0; i < N; i++) begin : g_chan
    ext_irq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[i]),
      .sense_i    (sense[2*i+:2]),
      .mode_wr_i  (mode_wr),
      .clr_i      (ack_i[i] | w1c[i]),
      .edge_o     (edge_evt[i]),
      .pend_o     (pend[i]),
      .low_async_o(low_async[i])
    );
    assign lvl_sel[i] = (sense[2*i+:2] == SENSE_LOW);
  end

  assign irq_o  = pend & mask_q & {N{gie_i}};
  assign wake_o = |(low_async & mask_q);
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_pkg::*;
#(
  parameter int N  = 2,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  pin_i,
  input logic          gie_i,
  input logic [N-1:0]  ack_i,
  input logic [1:0]    reg_addr_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic [N-1:0]  irq_o,
  input logic          wake_o,
  input logic [N-1:0]  edge_evt,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  lvl_sel,
  input logic [N-1:0]  mask_q
);
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == ADDR_CTRL |-> (reg_rdata_o >> (2 * N)) == '0);

  a_r3_edge_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(edge_evt & ~lvl_sel) |=>
      ((pend & $past(edge_evt & ~lvl_sel) & ~lvl_sel) == ($past(edge_evt & ~lvl_sel) & ~lvl_sel)));

  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(ack_i & ~edge_evt & ~lvl_sel) |=>
      ((pend & $past(ack_i & ~edge_evt & ~lvl_sel) & ~lvl_sel) == '0));

  a_r7_gie_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> irq_o == '0);

  a_r7_mask_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~mask_q) == '0);

  a_r8_wake_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !(&pin_i));
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.N(N), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_i      (pin_i),
  .gie_i      (gie_i),
  .ack_i      (ack_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .edge_evt   (edge_evt),
  .pend       (pend),
  .lvl_sel    (lvl_sel),
  .mask_q     (mask_q)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 2;
  localparam int DW = 8;
  localparam int WATCHDOG = 20000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pin_i = '1;
  logic          gie_i = 1'b0;
  logic [N-1:0]  ack_i = '0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_addr_i = 2'd0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic [N-1:0]  irq_o;
  logic          wake_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ext_irq_sense #(.N(N), .DW(DW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .gie_i(gie_i), .ack_i(ack_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // called at a negedge; write happens at the next posedge
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [DW-1:0] exp);
    reg_addr_i = a;
    #1;
    check(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic ack(input logic [N-1:0] v);
    ack_i = v;
    @(negedge clk_i);
    ack_i = '0;
  endtask

  task automatic t_reset;
    rd("R10 ctrl", 2'd0, 8'h00);
    rd("R10 mask", 2'd1, 8'h00);
    rd("R10 pend", 2'd2, 8'h00);
    check("R10 irq", 32'(irq_o), 0);
    check("R10 wake", 32'(wake_o), 0);
  endtask

  task automatic t_reserved;
    wr(2'd0, 8'hFF);
    rd("R1 reserved", 2'd0, 8'h0F);
    wr(2'd0, 8'hA4);
    rd("R1 fields", 2'd0, 8'h04);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_level;
    wr(2'd1, 8'h03);
    gie_i = 1'b1;
    pin_i[0] = 1'b0;
    #1 check("R8 wake async", 32'(wake_o), 1);
    cyc(3);
    check("R2 level irq", 32'(irq_o), 32'h1);
    cyc(5);
    check("R2 level held", 32'(irq_o), 32'h1);
    pin_i[0] = 1'b1;
    #1 check("R8 wake drops", 32'(wake_o), 0);
    cyc(3);
    check("R2 not latched", 32'(irq_o), 0);
    rd("R2 pend", 2'd2, 8'h00);
  endtask

  task automatic t_wake_masked;
    wr(2'd1, 8'h02);
    pin_i[0] = 1'b0;
    #1 check("R8 wake masked", 32'(wake_o), 0);
    cyc(3);
    pin_i[0] = 1'b1;
    cyc(3);
    wr(2'd1, 8'h03);
  endtask

  task automatic t_fall;
    wr(2'd0, 8'h0A);
    pin_i[0] = 1'b0;
    cyc(3);
    check("R3 fall sets", 32'(irq_o), 32'h1);
    pin_i[0] = 1'b1;
    cyc(3);
    check("R3 sticky", 32'(irq_o), 32'h1);
    ack(2'b10);
    check("R6 other ack", 32'(irq_o), 32'h1);
    ack(2'b01);
    check("R6 ack clears", 32'(irq_o), 0);
    pin_i[1] = 1'b0;
    cyc(3);
    pin_i[1] = 1'b1;
    cyc(3);
    wr(2'd2, 8'h00);
    rd("R6 write zero", 2'd2, 8'h02);
    wr(2'd2, 8'h02);
    rd("R6 w1c", 2'd2, 8'h00);
  endtask

  task automatic t_rise;
    wr(2'd0, 8'h03);
    pin_i[0] = 1'b0;
    cyc(3);
    check("R4 fall ignored", 32'(irq_o), 0);
    pin_i[0] = 1'b1;
    cyc(3);
    check("R4 rise sets", 32'(irq_o), 32'h1);
    ack(2'b01);
  endtask

  task automatic t_any;
    wr(2'd0, 8'h01);
    pin_i[0] = 1'b0;
    cyc(3);
    check("R5 fall sets", 32'(irq_o), 32'h1);
    ack(2'b01);
    check("R5 cleared", 32'(irq_o), 0);
    // pulse just over one period
    pin_i[0] = 1'b1;
    #(CLK_PERIOD + 2);
    pin_i[0] = 1'b0;
    cyc(4);
    check("R5 short pulse", 32'(irq_o), 32'h1);
    ack(2'b01);
    pin_i[0] = 1'b1;
    cyc(3);
    ack(2'b01);
  endtask

  task automatic t_gate;
    wr(2'd0, 8'h02);
    pin_i[0] = 1'b0;
    cyc(3);
    pin_i[0] = 1'b1;
    gie_i = 1'b0;
    #1 check("R7 gie off", 32'(irq_o), 0);
    gie_i = 1'b1;
    wr(2'd1, 8'h02);
    check("R7 mask off", 32'(irq_o), 0);
    rd("R7 still pend", 2'd2, 8'h01);
    wr(2'd1, 8'h03);
    check("R7 both on", 32'(irq_o), 32'h1);
    ack(2'b01);
    cyc(2);
  endtask

  task automatic t_mode_wr;
    wr(2'd0, 8'h03);
    cyc(2);
    pin_i[0] = 1'b0;
    cyc(2);
    wr(2'd0, 8'h02);
    cyc(3);
    check("R9 no spurious", 32'(irq_o), 0);
    rd("R9 pend", 2'd2, 8'h00);
    pin_i[0] = 1'b1;
    cyc(3);
    pin_i[0] = 1'b0;
    cyc(3);
    check("R9 later edge", 32'(irq_o), 32'h1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_reserved();
    t_level();
    t_wake_masked();
    t_fall();
    t_rise();
    t_any();
    t_gate();
    t_mode_wr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule